// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-side controller of a small byte-wide nonvolatile store of 256 or 512 bytes. It runs in the system clock domain. Its inputs are the two bus lines, already filtered and synchronised, plus one-cycle strobes that an upstream detector raises for start and stop conditions. It answers on the data line through an active-high pull-down enable. It recognises its device address word, acknowledges it, loads a memory address, and serves current-address, random and sequential reads from an internal address counter.

Received write bytes go to a page buffer of eight bytes. A stop condition commits that buffer as a timed internal write cycle, which then drains into the memory array model one byte per clock. While that cycle runs, the block refuses to acknowledge any device word, so a bus master can poll for completion. In the 512-byte build, the third select bit of the device word does not select the device. It carries memory address bit 8 instead.

Top module: `ee_serial_slave`

## Requirements
- R1: A device word is eight bits, MSB first. It is the code 1010, then select bits S2, S1, S0, then a direction bit (1 = read, 0 = write). It is acknowledged (data pulled low during the ninth clock) only when the code matches and S2 and S1 equal pins 2 and 1.
- R2: In the 256-byte build, S0 must equal pin 0. In the 512-byte build, S0 is not compared; in a write word it becomes memory address bit 8.
- R3: After a device word that is not acknowledged, the block drives nothing until the next start condition. It never drives the data line while it is unselected.
- R4: In a write, the memory-address byte and every data byte are acknowledged. Data bytes land at successive addresses, and the low three address bits wrap within the 8-byte page, so later bytes overwrite earlier ones. The bytes are committed to the array at the stop condition.
- R5: While a committed write cycle is in progress, device words get no acknowledge. Once the cycle has ended, a write device word is acknowledged again. A write cycle only ever begins at a stop condition.
- R6: A random read is a write device word and an address byte, then a repeated start and a read device word. It returns the byte at the loaded address.
- R7: After each read byte, a master acknowledge (0) makes the block return the byte at the next address. The address wraps from the last location to 0, and reading continues across the wrap.
- R8: A current-address read returns the byte after the last one accessed. After a write, that address is the next location within the same page, wrapped.
- R9: A master no-acknowledge after a read byte parks the block. The data line stays released for any further clocks until a start or stop condition.
- R10: The data line enable changes only while the clock is low, never while it is high. Start and stop strobes release it on the next cycle.
- R11: Reset releases the data line and sets the address counter to 0. Array contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Filtered bus clock level |
| sda_i | input | 1 | Filtered bus data level (wired-AND of all drivers) |
| start_i | input | 1 | One-cycle strobe for a start or repeated-start condition |
| stop_i | input | 1 | One-cycle strobe for a stop condition |
| dev_pins_i | input | 3 | Hard-wired device select pins |
| sda_oe_o | output | 1 | Pull data line low when 1 |

## Verification
A corrupted bit counter or state register shows up at the ports within one byte. Either an acknowledge appears in the wrong clock, or read data comes out shifted and is caught at the very next compared byte. A wrong address counter or wrong page-wrap arithmetic stays hidden until the next read. For that reason every write is followed by a current-address read and a sequential read that crosses both the page boundary and the array's top. A write cycle that never ends or never starts shows up as polling replies in the wrong order. A release missed after a no-acknowledge shows up as a low bit in the clocks that follow.

// File: rtl/ee_pkg.sv
// Shared definitions for the serial memory slave.
// Assumes: one byte lane; the device code is fixed by the bus convention.
package ee_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVWORD,
        ST_MEMADDR,
        ST_WRBYTE,
        ST_RDBYTE,
        ST_PARKED
    } eng_state_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/ee_mem_array.sv
// Register-array stand-in for the nonvolatile cells.
// Assumes: one write port and one asynchronous read port; no reset, so the
// contents survive a controller reset.
module ee_mem_array #(
    parameter int MEM_BYTES = 512,
    parameter int AW        = 9
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] cells [MEM_BYTES];

    // store one byte per cycle from the page writer
    always_ff @(posedge clk) begin
        if (we_i) cells[waddr_i] <= wdata_i;
    end

    assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/ee_page_writer.sv
// Page buffer and timed write cycle.
// Collects data bytes of the current page. A commit with at least one byte
// pending holds busy for WC_CYCLES clocks, then drains the marked entries
// into the array, one per clock.
// Assumes: no new bytes arrive while busy (the engine refuses selection).
module ee_page_writer #(
    parameter int PAGE_BYTES = 8,
    parameter int AW         = 9,
    parameter int WC_CYCLES  = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic          commit_i,
    output logic          busy_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [7:0]    mem_wdata_o
);
    localparam int PW = $clog2(PAGE_BYTES);
    localparam int TW = $clog2(WC_CYCLES + 1);

    logic [7:0]           pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mark;
    logic [AW-PW-1:0]     base;
    logic [TW-1:0]        timer;
    logic                 drain;
    logic [PW-1:0]        idx;
    logic                 busy_q;

    // hold incoming page bytes (storage only, no reset needed)
    always_ff @(posedge clk) begin
        if (wr_valid_i) pbuf[wr_addr_i[PW-1:0]] <= wr_data_i;
    end

    // mark pending bytes, run the wait timer, then drain the page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark   <= '0;
            base   <= '0;
            timer  <= '0;
            drain  <= 1'b0;
            idx    <= '0;
            busy_q <= 1'b0;
        end else begin
            if (wr_valid_i) begin
                mark[wr_addr_i[PW-1:0]] <= 1'b1;
                base <= wr_addr_i[AW-1:PW];
            end
            if (commit_i && !busy_q && (|mark)) begin
                busy_q <= 1'b1;
                timer  <= TW'(WC_CYCLES - 1);
                drain  <= 1'b0;
                idx    <= '0;
            end else if (busy_q && !drain) begin
                if (timer == '0) drain <= 1'b1;
                else             timer <= timer - 1'b1;
            end else if (drain) begin
                mark[idx] <= 1'b0;
                idx       <= idx + 1'b1;
                if (idx == PW'(PAGE_BYTES - 1)) begin
                    drain  <= 1'b0;
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign busy_o      = busy_q;
    assign mem_we_o    = drain & mark[idx];
    assign mem_addr_o  = {base, idx};
    assign mem_wdata_o = pbuf[idx];
endmodule

// File: rtl/ee_proto_engine.sv
// Bus protocol state machine.
// Counts clock edges within each 9-bit slot. It samples data on rising
// edges and changes the line enable only after falling edges. It decodes
// the device word, loads and advances the address counter, and returns
// read data MSB first.
// Assumes: scl_i and sda_i are glitch-free levels, and start_i and stop_i
// are single-cycle strobes aligned with them.
module ee_proto_engine
    import ee_pkg::*;
#(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 8,
    parameter int AW         = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic [2:0]    pin_i,
    input  logic          busy_i,
    input  logic [7:0]    rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          sel_o,
    output logic          sda_oe_o
);
    localparam int PW   = $clog2(PAGE_BYTES);
    localparam bit WIDE = (MEM_BYTES > 256);

    eng_state_t    state, nxt;
    logic          scl_q, rise, fall;
    logic [3:0]    cnt;
    logic [7:0]    sh, tx;
    logic          hi_q, mack, oe;
    logic [AW-1:0] cur, load_addr, page_next;
    logic          dev_hit;

    assign rise = scl_i & ~scl_q;
    assign fall = ~scl_i & scl_q;

    // device word compare; the low select bit is skipped in the wide build
    always_comb begin
        dev_hit = (sh[7:4] == DEV_CODE) && (sh[3] == pin_i[2]) &&
                  (sh[2] == pin_i[1]) && (WIDE || (sh[1] == pin_i[0]));
    end

    // memory address from the address byte plus the stored high bit
    always_comb begin
        load_addr = AW'(sh);
        if (WIDE) load_addr[AW-1] = hi_q;
    end

    // next write address, wrapping inside the page
    assign page_next = {cur[AW-1:PW], cur[PW-1:0] + PW'(1)};

    // protocol sequencing per bus clock edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            nxt   <= ST_IDLE;
            scl_q <= 1'b1;
            cnt   <= '0;
            sh    <= '0;
            tx    <= '0;
            hi_q  <= 1'b0;
            mack  <= 1'b1;
            oe    <= 1'b0;
            cur   <= '0;
        end else begin
            scl_q <= scl_i;
            if (start_i) begin
                state <= ST_DEVWORD;
                cnt   <= '0;
                oe    <= 1'b0;
            end else if (stop_i) begin
                state <= ST_IDLE;
                cnt   <= '0;
                oe    <= 1'b0;
            end else begin
                case (state)
                    ST_DEVWORD, ST_MEMADDR, ST_WRBYTE: begin
                        if (rise) begin
                            if (cnt < 4'd8) begin
                                sh  <= {sh[6:0], sda_i};
                                cnt <= cnt + 4'd1;
                            end else if (cnt == 4'd8) begin
                                cnt <= 4'd9;
                            end
                        end else if (fall && cnt == 4'd8) begin
                            if (state == ST_DEVWORD) begin
                                if (dev_hit && !busy_i) begin
                                    oe   <= 1'b1;
                                    hi_q <= sh[1];
                                    nxt  <= sh[0] ? ST_RDBYTE : ST_MEMADDR;
                                end else begin
                                    state <= ST_IDLE;
                                    cnt   <= '0;
                                end
                            end else if (state == ST_MEMADDR) begin
                                oe  <= 1'b1;
                                cur <= load_addr;
                                nxt <= ST_WRBYTE;
                            end else begin
                                oe  <= 1'b1;
                                cur <= page_next;
                                nxt <= ST_WRBYTE;
                            end
                        end else if (fall && cnt == 4'd9) begin
                            cnt   <= '0;
                            state <= nxt;
                            if (nxt == ST_RDBYTE) begin
                                tx <= rd_data_i;
                                oe <= ~rd_data_i[7];
                            end else begin
                                oe <= 1'b0;
                            end
                        end
                    end
                    ST_RDBYTE: begin
                        if (rise) begin
                            if (cnt < 4'd8) begin
                                cnt <= cnt + 4'd1;
                            end else if (cnt == 4'd8) begin
                                mack <= sda_i;
                                cnt  <= 4'd9;
                            end
                        end else if (fall) begin
                            if (cnt >= 4'd1 && cnt <= 4'd7) begin
                                tx <= {tx[6:0], 1'b0};
                                oe <= ~tx[6];
                            end else if (cnt == 4'd8) begin
                                oe  <= 1'b0;
                                cur <= cur + 1'b1;
                            end else if (cnt == 4'd9) begin
                                cnt <= '0;
                                if (!mack) begin
                                    tx <= rd_data_i;
                                    oe <= ~rd_data_i[7];
                                end else begin
                                    state <= ST_PARKED;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_valid_o = (state == ST_WRBYTE) && fall && (cnt == 4'd8) && !start_i && !stop_i;
    assign wr_addr_o  = cur;
    assign wr_data_o  = sh;
    assign rd_addr_o  = cur;
    assign sel_o      = (state != ST_IDLE) && (state != ST_PARKED);
    assign sda_oe_o   = oe;
endmodule

// File: rtl/ee_serial_slave.sv
// Top of the serial memory slave: protocol engine, page writer, array.
// Assumes: MEM_BYTES is 256 or 512, and PAGE_BYTES is a power of two.
module ee_serial_slave #(
    parameter int MEM_BYTES  = 512,
    parameter int PAGE_BYTES = 8,
    parameter int WC_CYCLES  = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [2:0] dev_pins_i,
    output logic       sda_oe_o
);
    localparam int AW = $clog2(MEM_BYTES);

    logic [AW-1:0] rd_addr, wr_addr, mem_addr;
    logic [7:0]    rd_data, wr_data, mem_wdata;
    logic          wr_valid, mem_we, wc_busy, eng_sel;

    ee_proto_engine #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .AW(AW)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .start_i(start_i), .stop_i(stop_i), .pin_i(dev_pins_i),
        .busy_i(wc_busy), .rd_data_i(rd_data), .rd_addr_o(rd_addr),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .sel_o(eng_sel), .sda_oe_o(sda_oe_o)
    );

    ee_page_writer #(.PAGE_BYTES(PAGE_BYTES), .AW(AW), .WC_CYCLES(WC_CYCLES)) u_pw (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .commit_i(stop_i), .busy_o(wc_busy),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
    );

    ee_mem_array #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_mem (
        .clk(clk), .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(mem_wdata),
        .raddr_i(rd_addr), .rdata_o(rd_data)
    );
endmodule

// File: rtl/ee_serial_slave_chk.sv
// Protocol checker bound to the slave top: line-enable timing, release
// rules and the origin of write cycles.
module ee_serial_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic start_i,
    input logic stop_i,
    input logic sda_oe,
    input logic busy,
    input logic engaged
);
    // R3
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !engaged |-> !sda_oe);

    // R10
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R10
    steady_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !$past(start_i) && !$past(stop_i)) |-> $stable(sda_oe));

    // R10
    strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i || stop_i) |=> !sda_oe);

    // R5
    cycle_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_i));
endmodule

bind ee_serial_slave ee_serial_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .start_i(start_i),
    .stop_i(stop_i), .sda_oe(sda_oe_o), .busy(wc_busy), .engaged(eng_sel)
);

// File: tb/ee_serial_slave_test.sv
// Bench: drives the bus at the bit level, keeps an arithmetic model of the
// array, and sweeps select codes, page wrap, polling and read wrap.
module ee_serial_slave_test;
    localparam logic [2:0] PINS = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic start_p = 1'b0;
    logic stop_p = 1'b0;
    logic sda_oe;
    wire  bus = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_err = 0;
    int unstable = 0;
    bit done = 1'b0;
    logic [7:0] model [512];

    always #5 clk = ~clk;

    ee_serial_slave #(.MEM_BYTES(512), .PAGE_BYTES(8), .WC_CYCLES(200)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(bus),
        .start_i(start_p), .stop_i(stop_p), .dev_pins_i(PINS), .sda_oe_o(sda_oe)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_chk++;
        if (actual !== expected) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    function automatic logic [7:0] devw(input logic a8, input logic rd);
        return {4'b1010, PINS[2], PINS[1], a8, rd};
    endfunction

    task automatic clock_bit(input logic b, output logic seen);
        @(negedge clk) sda_m = b;
        repeat (3) @(negedge clk);
        scl = 1'b1;
        repeat (2) @(negedge clk);
        seen = bus;
        repeat (2) @(negedge clk);
        if (bus !== seen) unstable++;
        scl = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic bus_start();
        @(negedge clk) sda_m = 1'b1;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (3) @(negedge clk);
        sda_m = 1'b0;
        start_p = 1'b1;
        @(negedge clk) start_p = 1'b0;
        repeat (2) @(negedge clk);
        scl = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_stop();
        @(negedge clk) sda_m = 1'b0;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (3) @(negedge clk);
        sda_m = 1'b1;
        stop_p = 1'b1;
        @(negedge clk) stop_p = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    task automatic wait_ready(output int nacks, output logic ready);
        logic a;
        nacks = 0;
        ready = 1'b0;
        for (int t = 0; t < 30 && !ready; t++) begin
            bus_start();
            send_byte(devw(1'b0, 1'b0), a);
            bus_stop();
            if (a) ready = 1'b1;
            else   nacks++;
        end
    endtask

    task automatic random_setup(input logic [8:0] addr);
        logic a;
        bus_start();
        send_byte(devw(addr[8], 1'b0), a);
        check("R6 dummy write device word ack", int'(a), 1);
        send_byte(addr[7:0], a);
        check("R6 address byte ack", int'(a), 1);
        bus_start();
        send_byte(devw(1'b0, 1'b1), a);
        check("R6 read device word ack", int'(a), 1);
    endtask

    initial begin
        logic a, rdy, s;
        logic [7:0] d;
        int nk, lows;

        repeat (5) @(negedge clk);
        // R11: line released during and after reset
        check("R11 reset release", int'(sda_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 idle after reset", int'(sda_oe), 0);

        // R1 R2 R3: sweep of all select codes (wide build ignores S0)
        for (int c = 0; c < 8; c++) begin
            bus_start();
            send_byte({4'b1010, 3'(c), 1'b0}, a);
            check("R1 R2 select sweep", int'(a), (c[2:1] == 2'b10) ? 1 : 0);
            if (!a) begin
                send_byte(8'h00, a);
                check("R3 no drive after mismatch", int'(a), 0);
            end
            bus_stop();
        end
        // R1: wrong device code with matching select bits
        bus_start();
        send_byte({4'b1011, PINS[2], PINS[1], 2'b00}, a);
        check("R1 wrong device code", int'(a), 0);
        bus_stop();

        // R4: ten bytes from page offset 6 wrap within page 0x1F8
        bus_start();
        send_byte(devw(1'b1, 1'b0), a);
        check("R4 write device word ack", int'(a), 1);
        send_byte(8'hFE, a);
        check("R4 address byte ack", int'(a), 1);
        for (int k = 0; k < 10; k++) begin
            send_byte(8'hA0 + 8'(k), a);
            check("R4 data byte ack", int'(a), 1);
            model[9'h1F8 + 9'((6 + k) % 8)] = 8'hA0 + 8'(k);
        end
        bus_stop();

        // R5: polling refused first, then accepted
        wait_ready(nk, rdy);
        check("R5 busy refuses device word", int'(nk > 0), 1);
        check("R5 accepted after cycle", int'(rdy), 1);

        // R8: current address after write wraps to page start 0x1F8
        bus_start();
        send_byte(devw(1'b0, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R8 current read after page write", int'(d), int'(model[9'h1F8]));

        // R4: fill page 0
        bus_start();
        send_byte(devw(1'b0, 1'b0), a);
        send_byte(8'h00, a);
        for (int k = 0; k < 8; k++) begin
            send_byte(8'h30 + 8'(k), a);
            check("R4 page 0 data ack", int'(a), 1);
            model[k] = 8'h30 + 8'(k);
        end
        bus_stop();
        wait_ready(nk, rdy);
        check("R5 ready after page 0", int'(rdy), 1);

        // R6 R7: random read at 0x1FC, sequential across the top
        random_setup(9'h1FC);
        for (int i = 0; i < 8; i++) begin
            recv_byte(i < 7, d);
            check(i == 0 ? "R6 random read data" : "R7 sequential wrap data",
                  int'(d), int'(model[9'((9'h1FC + i) % 512)]));
        end
        bus_stop();

        // R8: current address continues after the last read
        bus_start();
        send_byte(devw(1'b0, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R8 current read continues", int'(d), int'(model[4]));

        // R9: no-acknowledge without stop parks the block
        random_setup(9'h002);
        recv_byte(1'b0, d);
        check("R6 random read at 2", int'(d), int'(model[2]));
        lows = 0;
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, s);
            if (s == 1'b0) lows++;
        end
        check("R9 parked line released", lows, 0);
        bus_stop();

        // R2: bit 8 taken from the select field in the wide build
        bus_start();
        send_byte(devw(1'b1, 1'b0), a);
        send_byte(8'h05, a);
        send_byte(8'h5A, a);
        check("R2 high-half write ack", int'(a), 1);
        model[9'h105] = 8'h5A;
        bus_stop();
        wait_ready(nk, rdy);
        random_setup(9'h105);
        recv_byte(1'b0, d);
        bus_stop();
        check("R2 high-half read", int'(d), 8'h5A);
        random_setup(9'h005);
        recv_byte(1'b0, d);
        bus_stop();
        check("R2 low-half untouched", int'(d), int'(model[5]));

        // R11: reset clears the counter and keeps the array
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_start();
        send_byte(devw(1'b0, 1'b1), a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R11 counter zero after reset", int'(d), int'(model[0]));

        // R10: line never moved while the clock was high
        check("R10 steady while clock high", unstable, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule